// File: doc/BRIEF.md
# Receive Ring Frame Mover

This block accepts Ethernet frames one byte at a time from an internal switching fabric and holds them in an ingress buffer whose capacity is counted in bytes. A frame becomes eligible for transfer only after its final byte has been buffered. The frame at the buffer head is then copied into host memory. The copy starts at a buffer address that software placed into a circular ring of receive slots ahead of time.

Software hands buffers to the engine through a post port. Each post fills the slot at the producer index and gives that slot to hardware. The engine consumes slots strictly in ring order. It writes the frame as 32-bit beats over a simple valid/ready write channel. When a frame finishes, it records the frame length in the slot, returns the slot to software, raises that slot's completion flag and pulses a completion report.

The fabric is never stalled. Malformed or oversized frames are thrown away as they arrive. A frame that sits at the head with no hardware-owned slot for too long is skipped. Every discarded frame is counted. One instance serves a single port and a single ring; an external selector decides which instance a frame goes to.

Top module: `rx_ring_dma`

## Requirements
- R1: No memory write beat belonging to a frame is issued before the byte marked end-of-frame for that frame has been accepted into the ingress buffer.
- R2: Byte k of a frame is written to the byte at slot address + k, packed little-endian: byte k sits in lane k mod 4 of the beat at slot address + 4*floor(k/4). A beat's strobe bit is set only for lanes holding frame bytes, so the final beat of a frame whose length is not a multiple of 4 leaves the following bytes untouched. Slot addresses are multiples of 4.
- R3: A post stores its address in the slot at the producer index, hands that slot to hardware and advances the producer index modulo the ring size. A post that finds the slot at the producer index still owned by hardware is ignored, and its address is never written.
- R4: Frames consume slots in consumer-index order, and the index wraps modulo the ring size.
- R5: When the last beat of a frame is accepted, the slot is returned to software. In the following cycle the completion flag of that slot is 1, and a one-cycle completion report carries the slot index and the frame length in bytes. Reposting the slot clears its completion flag.
- R6: A consumed slot is not used again until software reposts it.
- R7: Buffer capacity is FIFO_BYTES bytes. A frame that fits exactly is delivered. A frame that outgrows the free space is discarded whole, with no memory write, and the drop count rises by one.
- R8: A frame whose end-of-frame byte carries the error marker is discarded whole, with no memory write, and the drop count rises by one.
- R9: A complete frame at the buffer head is skipped, and the drop count rises by one, once STARVE_CYCLES consecutive cycles have passed with no hardware-owned slot at the consumer index. A slot posted within that window receives the frame.
- R10: While the write channel's ready is low, a pending beat keeps valid high and holds its address, data and strobe unchanged.
- R11: After reset, no beat is pending, no completion is reported, all completion flags are 0 and the drop count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A frame byte is present this cycle |
| inData | input | 8 | Frame byte |
| inSof | input | 1 | Byte is the first of a frame |
| inEof | input | 1 | Byte is the last of a frame |
| inErr | input | 1 | Frame is bad; sampled together with inEof |
| postValid | input | 1 | Software posts a buffer address |
| postAddr | input | ADDR_W | Buffer address being posted |
| memValid | output | 1 | Write beat pending |
| memReady | input | 1 | Memory accepts the beat |
| memAddr | output | ADDR_W | Beat byte address |
| memData | output | MEM_W | Beat data, little-endian lanes |
| memStrb | output | MEM_W/8 | Per-lane byte enables |
| slotDone | output | RING_SLOTS | Completion flag per ring slot |
| cplValid | output | 1 | One-cycle completion report |
| cplIdx | output | log2(RING_SLOTS) | Slot that just completed |
| cplLen | output | LEN_W | Length of the completed frame in bytes |
| dropCount | output | DROP_W | Count of discarded frames, wrapping |

## Verification
The bench builds the engine with a 32-byte ingress buffer, a 4-slot ring and an 8-cycle starvation window. That small buffer lets a sweep cover every frame length from one byte up to exactly full capacity. The sweep wraps the ring eight times and lands each frame at a shifting address. The small sizes also make overflow, ring exhaustion and head-of-line starvation reachable in a few dozen cycles, so an ignored post, a consumed slot left unposted, and a post arriving inside the starvation window can each be set up and observed in memory directly.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;

  // Strobes from the control FSM to the beat datapath
  typedef struct packed {
    logic beginFrame;  // latch the slot address, clear beat state
    logic takeByte;    // move the head byte into the pack register
  } dpCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_DRAIN,
    ST_SKIP
  } ctlState_t;

endpackage

// File: rtl/rx_ingress_fifo.sv
// Byte-wide store-and-forward buffer. Each entry carries an end-of-frame
// marker beside the data byte; a frame is committed only at its last byte.
module rx_ingress_fifo #(
  parameter int FIFO_BYTES = 2048
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] inData,
  input  logic       inSof,
  input  logic       inEof,
  input  logic       inErr,
  input  logic       popByte,
  output logic [7:0] headByte,
  output logic       headLast,
  output logic       frameReady,
  output logic       discardPulse
);
  localparam int AW = $clog2(FIFO_BYTES);
  localparam int PW = AW + 1;

  logic [8:0]    fifoMem [FIFO_BYTES];
  logic [PW-1:0] rdPtr, comPtr, wrPtr, frameCnt;
  logic          inFrame, ovf;

  logic [PW-1:0] startPtr, usedNow;
  logic          accept, fits, ovfEff, wrEn, goodEnd, badEnd;

  always_comb begin
    startPtr = inSof ? comPtr : wrPtr;
    usedNow  = startPtr - rdPtr;
    fits     = usedNow < PW'(FIFO_BYTES);
    accept   = inValid && (inSof || inFrame);
    ovfEff   = inSof ? 1'b0 : ovf;
    wrEn     = accept && fits && !ovfEff;
    goodEnd  = wrEn && inEof && !inErr;
    badEnd   = accept && inEof && !goodEnd;
  end

  always_ff @(posedge clk) begin
    if (wrEn) fifoMem[startPtr[AW-1:0]] <= {inEof, inData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr    <= '0;
      comPtr   <= '0;
      wrPtr    <= '0;
      frameCnt <= '0;
      inFrame  <= 1'b0;
      ovf      <= 1'b0;
    end else begin
      if (accept) begin
        if (wrEn) wrPtr <= startPtr + PW'(1);
        else      wrPtr <= startPtr;
        ovf <= ovfEff || !fits;
      end
      if (badEnd)  wrPtr  <= comPtr;
      if (goodEnd) comPtr <= startPtr + PW'(1);
      if (accept && inEof)      inFrame <= 1'b0;
      else if (accept && inSof) inFrame <= 1'b1;
      if (popByte) rdPtr <= rdPtr + PW'(1);
      frameCnt <= frameCnt + PW'(goodEnd) - PW'(popByte && headLast);
    end
  end

  assign headByte     = fifoMem[rdPtr[AW-1:0]][7:0];
  assign headLast     = fifoMem[rdPtr[AW-1:0]][8];
  assign frameReady   = frameCnt != '0;
  assign discardPulse = badEnd;

endmodule

// File: rtl/rx_slot_table.sv
// Circular receive ring: per-slot buffer address, length, owner and done.
module rx_slot_table #(
  parameter int RING_SLOTS = 16,
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          postValid,
  input  logic [ADDR_W-1:0]             postAddr,
  input  logic                          retire,
  input  logic [LEN_W-1:0]              retireLen,
  output logic                          headOwned,
  output logic [ADDR_W-1:0]             headAddr,
  output logic [RING_SLOTS-1:0]         slotDone,
  output logic                          cplValid,
  output logic [$clog2(RING_SLOTS)-1:0] cplIdx,
  output logic [LEN_W-1:0]              cplLen
);
  localparam int IW = $clog2(RING_SLOTS);

  logic [IW-1:0]     prodIdx, consIdx;
  logic [ADDR_W-1:0] slotAddr [RING_SLOTS];
  logic [LEN_W-1:0]  slotLen  [RING_SLOTS];
  logic [RING_SLOTS-1:0] slotOwn;
  logic              postHit;

  assign postHit = postValid && !slotOwn[prodIdx];

  for (genvar gi = 0; gi < RING_SLOTS; gi++) begin : g_slot
    logic [ADDR_W-1:0] addrQ;
    logic [LEN_W-1:0]  lenQ;
    logic              ownQ, doneQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrQ <= '0;
        lenQ  <= '0;
        ownQ  <= 1'b0;
        doneQ <= 1'b0;
      end else begin
        if (postHit && prodIdx == IW'(gi)) begin
          addrQ <= postAddr;
          ownQ  <= 1'b1;
          doneQ <= 1'b0;
        end
        if (retire && consIdx == IW'(gi)) begin
          lenQ  <= retireLen;
          ownQ  <= 1'b0;
          doneQ <= 1'b1;
        end
      end
    end

    assign slotAddr[gi] = addrQ;
    assign slotLen[gi]  = lenQ;
    assign slotOwn[gi]  = ownQ;
    assign slotDone[gi] = doneQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prodIdx  <= '0;
      consIdx  <= '0;
      cplValid <= 1'b0;
      cplIdx   <= '0;
    end else begin
      cplValid <= retire;
      if (postHit) prodIdx <= prodIdx + IW'(1);
      if (retire) begin
        cplIdx  <= consIdx;
        consIdx <= consIdx + IW'(1);
      end
    end
  end

  assign headOwned = slotOwn[consIdx];
  assign headAddr  = slotAddr[consIdx];
  assign cplLen    = slotLen[cplIdx];

endmodule

// File: rtl/rx_dma_datapath.sv
// Packs head bytes into little-endian beats and presents them on the
// write channel, one beat at a time, held until accepted.
module rx_dma_datapath
  import rx_ring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int MEM_W  = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtl_t               ctl,
  input  logic [7:0]           headByte,
  input  logic                 headLast,
  input  logic [ADDR_W-1:0]    baseIn,
  input  logic                 memReady,
  output logic                 memValid,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [MEM_W-1:0]     memData,
  output logic [MEM_W/8-1:0]   memStrb,
  output logic                 wordPend,
  output logic                 lastBeatDone,
  output logic [LEN_W-1:0]     frameLen
);
  localparam int LANES = MEM_W / 8;
  localparam int LW    = $clog2(LANES);

  logic [ADDR_W-1:0] baseQ;
  logic [LEN_W-1:0]  beatIdx, lenQ;
  logic [LW-1:0]     lane;
  logic [MEM_W-1:0]  packQ;
  logic [LANES-1:0]  strbQ;
  logic              pendQ, lastQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ   <= '0;
      beatIdx <= '0;
      lenQ    <= '0;
      lane    <= '0;
      packQ   <= '0;
      strbQ   <= '0;
      pendQ   <= 1'b0;
      lastQ   <= 1'b0;
    end else if (ctl.beginFrame) begin
      baseQ   <= baseIn;
      beatIdx <= '0;
      lenQ    <= '0;
      lane    <= '0;
      strbQ   <= '0;
      pendQ   <= 1'b0;
      lastQ   <= 1'b0;
    end else begin
      if (pendQ && memReady) begin
        pendQ   <= 1'b0;
        strbQ   <= '0;
        lane    <= '0;
        beatIdx <= beatIdx + LEN_W'(1);
      end
      if (ctl.takeByte) begin
        packQ[{lane, 3'b000} +: 8] <= headByte;
        strbQ[lane] <= 1'b1;
        lenQ        <= lenQ + LEN_W'(1);
        lane        <= lane + LW'(1);
        if (lane == LW'(LANES - 1) || headLast) begin
          pendQ <= 1'b1;
          lastQ <= headLast;
        end
      end
    end
  end

  assign memValid     = pendQ;
  assign memAddr      = baseQ + ADDR_W'({beatIdx, {LW{1'b0}}});
  assign memData      = packQ;
  assign memStrb      = strbQ;
  assign wordPend     = pendQ;
  assign lastBeatDone = pendQ && lastQ && memReady;
  assign frameLen     = lenQ;

endmodule

// File: rtl/rx_dma_control.sv
// Head-of-buffer sequencing: wait for a slot, fill, drain, or skip on
// starvation. Also keeps the discard count.
module rx_dma_control
  import rx_ring_pkg::*;
#(
  parameter int STARVE_CYCLES = 64,
  parameter int DROP_W        = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameReady,
  input  logic              headOwned,
  input  logic              headLast,
  input  logic              wordPend,
  input  logic              lastBeatDone,
  input  logic              fifoDiscard,
  output dpCtl_t            ctl,
  output logic              popByte,
  output logic              retire,
  output logic [DROP_W-1:0] dropCount
);
  localparam int SW = $clog2(STARVE_CYCLES + 1);

  ctlState_t     state, nxtState;
  logic [SW-1:0] starveCnt;
  logic          headDrop, starving;

  always_comb begin
    nxtState = state;
    ctl      = '0;
    popByte  = 1'b0;
    retire   = 1'b0;
    headDrop = 1'b0;
    starving = 1'b0;
    unique case (state)
      ST_IDLE: if (frameReady) begin
        if (headOwned) begin
          ctl.beginFrame = 1'b1;
          nxtState       = ST_FILL;
        end else if (starveCnt == SW'(STARVE_CYCLES - 1)) begin
          headDrop = 1'b1;
          nxtState = ST_SKIP;
        end else begin
          starving = 1'b1;
        end
      end
      ST_FILL: if (!wordPend) begin
        ctl.takeByte = 1'b1;
        popByte      = 1'b1;
        if (headLast) nxtState = ST_DRAIN;
      end
      ST_DRAIN: if (lastBeatDone) begin
        retire   = 1'b1;
        nxtState = ST_IDLE;
      end
      ST_SKIP: begin
        popByte = 1'b1;
        if (headLast) nxtState = ST_IDLE;
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      starveCnt <= '0;
      dropCount <= '0;
    end else begin
      state     <= nxtState;
      starveCnt <= starving ? starveCnt + SW'(1) : '0;
      dropCount <= dropCount + DROP_W'(fifoDiscard) + DROP_W'(headDrop);
    end
  end

endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma
  import rx_ring_pkg::*;
#(
  parameter int FIFO_BYTES    = 2048,
  parameter int RING_SLOTS    = 16,
  parameter int ADDR_W        = 32,
  parameter int LEN_W         = 16,
  parameter int MEM_W         = 32,
  parameter int STARVE_CYCLES = 64,
  parameter int DROP_W        = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          inValid,
  input  logic [7:0]                    inData,
  input  logic                          inSof,
  input  logic                          inEof,
  input  logic                          inErr,
  input  logic                          postValid,
  input  logic [ADDR_W-1:0]             postAddr,
  output logic                          memValid,
  input  logic                          memReady,
  output logic [ADDR_W-1:0]             memAddr,
  output logic [MEM_W-1:0]              memData,
  output logic [MEM_W/8-1:0]            memStrb,
  output logic [RING_SLOTS-1:0]         slotDone,
  output logic                          cplValid,
  output logic [$clog2(RING_SLOTS)-1:0] cplIdx,
  output logic [LEN_W-1:0]              cplLen,
  output logic [DROP_W-1:0]             dropCount
);
  dpCtl_t            ctl;
  logic [7:0]        headByte;
  logic              headLast, frameReady, fifoDiscard, popByte;
  logic              headOwned, retire, wordPend, lastBeatDone;
  logic [ADDR_W-1:0] headAddr;
  logic [LEN_W-1:0]  frameLen;

  rx_ingress_fifo #(.FIFO_BYTES(FIFO_BYTES)) fifo_i (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inData(inData), .inSof(inSof), .inEof(inEof), .inErr(inErr),
    .popByte(popByte), .headByte(headByte), .headLast(headLast),
    .frameReady(frameReady), .discardPulse(fifoDiscard)
  );

  rx_slot_table #(.RING_SLOTS(RING_SLOTS), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) ring_i (
    .clk(clk), .rstN(rstN),
    .postValid(postValid), .postAddr(postAddr),
    .retire(retire), .retireLen(frameLen),
    .headOwned(headOwned), .headAddr(headAddr), .slotDone(slotDone),
    .cplValid(cplValid), .cplIdx(cplIdx), .cplLen(cplLen)
  );

  rx_dma_control #(.STARVE_CYCLES(STARVE_CYCLES), .DROP_W(DROP_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .frameReady(frameReady), .headOwned(headOwned), .headLast(headLast),
    .wordPend(wordPend), .lastBeatDone(lastBeatDone), .fifoDiscard(fifoDiscard),
    .ctl(ctl), .popByte(popByte), .retire(retire), .dropCount(dropCount)
  );

  rx_dma_datapath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MEM_W(MEM_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .headByte(headByte), .headLast(headLast), .baseIn(headAddr),
    .memReady(memReady), .memValid(memValid), .memAddr(memAddr),
    .memData(memData), .memStrb(memStrb),
    .wordPend(wordPend), .lastBeatDone(lastBeatDone), .frameLen(frameLen)
  );

endmodule

// File: rtl/rx_ring_dma_chk.sv
module rx_ring_dma_chk #(
  parameter int RING_SLOTS = 16,
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int MEM_W      = 32,
  parameter int DROP_W     = 16
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          memValid,
  input logic                          memReady,
  input logic [ADDR_W-1:0]             memAddr,
  input logic [MEM_W-1:0]              memData,
  input logic [MEM_W/8-1:0]            memStrb,
  input logic [RING_SLOTS-1:0]         slotDone,
  input logic                          cplValid,
  input logic [$clog2(RING_SLOTS)-1:0] cplIdx,
  input logic [LEN_W-1:0]              cplLen,
  input logic [DROP_W-1:0]             dropCount
);
  localparam int LANES = MEM_W / 8;

  assert_beat_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(memAddr) && $stable(memData) && $stable(memStrb));

  // Strobes start at lane 0 and are contiguous
  assert_strb_contig_R2: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> memStrb[0] && ((memStrb & (memStrb + LANES'(1))) == '0));

  assert_cpl_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    cplValid |-> slotDone[cplIdx]);

  assert_cpl_len_R5: assert property (@(posedge clk) disable iff (!rstN)
    cplValid |-> cplLen != '0);

  assert_cpl_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    cplValid |=> !cplValid);

  // At most one fabric discard and one head skip per cycle (R7, R8, R9)
  assert_drop_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> DROP_W'(dropCount - $past(dropCount)) <= DROP_W'(2));

endmodule

bind rx_ring_dma rx_ring_dma_chk #(
  .RING_SLOTS(RING_SLOTS), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MEM_W(MEM_W), .DROP_W(DROP_W)
) chk_i (
  .clk(clk), .rstN(rstN), .memValid(memValid), .memReady(memReady),
  .memAddr(memAddr), .memData(memData), .memStrb(memStrb), .slotDone(slotDone),
  .cplValid(cplValid), .cplIdx(cplIdx), .cplLen(cplLen), .dropCount(dropCount)
);

// File: tb/rx_ring_dma_tb_top.sv
module rx_ring_dma_tb_top;
  localparam int FB = 32;
  localparam int RS = 4;
  localparam int SC = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, inSof = 1'b0, inEof = 1'b0, inErr = 1'b0;
  logic [7:0]  inData = '0;
  logic        postValid = 1'b0;
  logic [31:0] postAddr = '0;
  logic        memValid, memReady = 1'b1;
  logic [31:0] memAddr, memData;
  logic [3:0]  memStrb;
  logic [RS-1:0] slotDone;
  logic        cplValid;
  logic [1:0]  cplIdx;
  logic [15:0] cplLen;
  logic [7:0]  dropCount;

  rx_ring_dma #(.FIFO_BYTES(FB), .RING_SLOTS(RS), .STARVE_CYCLES(SC), .DROP_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inSof(inSof),
    .inEof(inEof), .inErr(inErr), .postValid(postValid), .postAddr(postAddr),
    .memValid(memValid), .memReady(memReady), .memAddr(memAddr), .memData(memData),
    .memStrb(memStrb), .slotDone(slotDone), .cplValid(cplValid), .cplIdx(cplIdx),
    .cplLen(cplLen), .dropCount(dropCount)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  logic [7:0] memImg [1024];
  int cplCount = 0, lastIdx = -1, lastLen = -1;
  int gapBeats = 0, stallErr = 0, cyc = 0, readyMode = 1;
  bit slowPhase = 0, holdPrev = 0;
  logic [31:0] prevAddr, prevData;

  always @(posedge clk) begin
    if (rstN) begin
      if (holdPrev && !(memValid && memAddr == prevAddr && memData == prevData)) stallErr++;
      holdPrev = memValid && !memReady;
      prevAddr = memAddr;
      prevData = memData;
      if (memValid && memReady)
        for (int k = 0; k < 4; k++)
          if (memStrb[k]) memImg[(memAddr + k) & 1023] = memData[8*k +: 8];
      if (cplValid) begin
        cplCount++;
        lastIdx = cplIdx;
        lastLen = cplLen;
      end
      if (slowPhase && memValid) gapBeats++;
    end
  end

  always @(negedge clk) begin
    cyc++;
    memReady <= (readyMode == 0) ? 1'b1 : (readyMode == 1) ? (cyc % 3 != 0) : 1'b0;
  end

  function automatic logic [7:0] byteOf(int seed, int i);
    return 8'((seed * 13 + i * 7 + 1) & 255);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 1024; i++) memImg[i] = 8'hEE;
  endtask

  task automatic post(input int addr);
    @(negedge clk);
    postValid = 1'b1;
    postAddr  = 32'(addr);
    @(negedge clk);
    postValid = 1'b0;
  endtask

  task automatic sendFrame(input int len, input int seed, input bit err, input int gap);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (gap > 0 && i > 0) begin
        inValid = 1'b0;
        repeat (gap) @(negedge clk);
      end
      inValid = 1'b1;
      inData  = byteOf(seed, i);
      inSof   = (i == 0);
      inEof   = (i == len - 1);
      inErr   = err && (i == len - 1);
    end
    @(negedge clk);
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0; inErr = 1'b0;
  endtask

  task automatic waitCpl(input int target);
    for (int i = 0; i < 3000 && cplCount < target; i++) @(negedge clk);
  endtask

  task automatic checkData(input int base, input int len, input int seed, input string tag);
    int mis = 0;
    for (int i = 0; i < len; i++) if (memImg[base + i] !== byteOf(seed, i)) mis++;
    chk(mis == 0, tag, mis, 0);
    if (len % 4 != 0)
      chk(memImg[base + len] == 8'hEE, {tag, " tail strobe"}, memImg[base + len], 8'hEE);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int base0;
    clearMem();
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(memValid == 0, "R11 memValid", memValid, 0);
    chk(cplValid == 0, "R11 cplValid", cplValid, 0);
    chk(slotDone == 0, "R11 slotDone", slotDone, 0);
    chk(dropCount == 0, "R11 dropCount", dropCount, 0);

    // Sweep every length 1..FB; ring wraps repeatedly (R2, R4, R5, R7 exact fit)
    for (int n = 0; n < FB; n++) begin
      base0 = (n % 16) * 64;
      post(base0);
      sendFrame(n + 1, n, 0, 0);
      waitCpl(n + 1);
      chk(lastIdx == n % RS, "R4 slot order", lastIdx, n % RS);
      chk(lastLen == n + 1, "R5 completion length", lastLen, n + 1);
      chk(slotDone[n % RS] == 1'b1, "R5 done flag", slotDone[n % RS], 1);
      checkData(base0, n + 1, n, n == FB - 1 ? "R7 full-capacity data" : "R2 data");
    end
    chk(slotDone == 4'hF, "R5 all done", slotDone, 15);

    // R3: ring full, extra post ignored
    clearMem();
    post(32'h000);
    chk(slotDone[0] == 1'b0, "R5 repost clears done", slotDone[0], 0);
    post(32'h040); post(32'h080); post(32'h0C0);
    post(32'h200);
    for (int f = 0; f < 4; f++) sendFrame(5 + f, 40 + f, 0, 0);
    waitCpl(FB + 4);
    chk(cplCount == FB + 4, "R4 burst completions", cplCount, FB + 4);
    for (int f = 0; f < 4; f++) checkData(f * 64, 5 + f, 40 + f, "R4 burst data");
    chk(memImg[32'h200] == 8'hEE, "R3 ignored post", memImg[32'h200], 8'hEE);
    chk(dropCount == 0, "R3 no drops", dropCount, 0);

    // R6 / R9: no owned slot, head frame skipped after the window
    sendFrame(8, 50, 0, 0);
    repeat (40) @(negedge clk);
    chk(dropCount == 1, "R9 starvation drop", dropCount, 1);
    chk(cplCount == FB + 4, "R6 no reuse of consumed slot", cplCount, FB + 4);
    sendFrame(6, 51, 0, 0);
    repeat (3) @(negedge clk);
    post(32'h100);
    waitCpl(FB + 5);
    checkData(32'h100, 6, 51, "R9 post within window");
    chk(dropCount == 1, "R9 no extra drop", dropCount, 1);

    // R8: error-marked frame discarded
    post(32'h180);
    sendFrame(10, 60, 1, 0);
    repeat (30) @(negedge clk);
    chk(dropCount == 2, "R8 error drop", dropCount, 2);
    chk(cplCount == FB + 5, "R8 no completion", cplCount, FB + 5);
    sendFrame(9, 61, 0, 0);
    waitCpl(FB + 6);
    checkData(32'h180, 9, 61, "R8 next frame");

    // R7: second frame outgrows free space while the first is stalled
    readyMode = 2;
    post(32'h200);
    sendFrame(24, 70, 0, 0);
    sendFrame(16, 71, 0, 0);
    repeat (10) @(negedge clk);
    chk(dropCount == 3, "R7 overflow drop", dropCount, 3);
    readyMode = 1;
    waitCpl(FB + 7);
    checkData(32'h200, 24, 70, "R7 survivor data");
    post(32'h280);
    sendFrame(FB + 1, 72, 0, 0);
    repeat (10) @(negedge clk);
    chk(dropCount == 4, "R7 oversize drop", dropCount, 4);
    sendFrame(12, 73, 0, 0);
    waitCpl(FB + 8);
    checkData(32'h280, 12, 73, "R7 slot kept");

    // R1: slow frame, no beat before its last byte
    readyMode = 0;
    post(32'h300);
    slowPhase = 1;
    sendFrame(6, 80, 0, 4);
    slowPhase = 0;
    chk(gapBeats == 0, "R1 store and forward", gapBeats, 0);
    waitCpl(FB + 9);
    checkData(32'h300, 6, 80, "R1 data");

    chk(stallErr == 0, "R10 beat held under stall", stallErr, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule